// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits at the front of a receive path and decides whether an incoming frame is kept. It sees the destination address of each frame as a stream of bytes. The first byte carries a start marker. Once six bytes have been seen, the block gives a single accept or reject verdict. The verdict is held until the next start marker, so the frame store behind the filter can sample it at any point during the rest of the frame.

The verdict comes from four sources, each set over a small write-only configuration bus:

- a programmed station address, which gives an exact unicast match;
- a 64-bit hash table for group addresses, indexed by six bits of the Ethernet CRC-32 of the destination;
- a broadcast-accept mode bit;
- a promiscuous mode bit.

The block does not store frames and does not check the frame check sequence.

Top module: `dst_addr_filter`

## Requirements
- R1: After reset, match_valid and match_accept are low. The station address, both hash words and the mode bits are all zero.
- R2: A frame starts on a cycle with rx_valid and rx_sof both high. match_valid goes low in the cycle after that start. It stays low while the address is incomplete and rises in the cycle after the sixth address byte. Cycles with rx_valid low do not count as bytes.
- R3: Once match_valid is high, match_valid and match_accept hold their values until the next start, whatever happens on the configuration bus. Bytes after the sixth that arrive without rx_sof are ignored.
- R4: Address byte 0 is the first byte received. The select codes are 0 (station low word: byte 2 in bits 31:24 down to byte 5 in bits 7:0) and 1 (station high word: byte 0 in bits 15:8, byte 1 in bits 7:0). A destination that equals the programmed station address is accepted. A unicast destination that differs from it in any byte is rejected unless promiscuous mode is set.
- R5: A destination with bit 0 of byte 0 set, and not all ones, is a group address. It is accepted when the hash bit at index idx is set, and rejected otherwise. idx[5] chooses hash word 0 (select 2) or hash word 1 (select 3), and idx[4:0] is the bit position within that word.
- R6: idx is bits 31:26 of a CRC-32 with polynomial 0x04C11DB7. The CRC register starts at all ones. It takes the six bytes in arrival order, least significant bit first, and the result is not inverted.
- R7: The all-ones destination is accepted exactly when mode bit 1 is set. This test is made before the hash lookup, so a hash table of all ones does not admit broadcasts.
- R8: When mode bit 0 is set, every frame is accepted. The mode word is written with select 4.
- R9: Writes with select codes 5, 6 and 7 change no configuration.
- R10: Bytes with rx_valid high and rx_sof low that arrive before any start marker produce no verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A byte is present on rx_data |
| rx_sof | input | 1 | Present byte is byte 0 of a new destination |
| rx_data | input | 8 | Destination address byte |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration word select |
| cfg_wdata | input | 32 | Configuration write data |
| match_valid | output | 1 | Verdict available |
| match_accept | output | 1 | Frame accepted (only meaningful with match_valid) |

## Verification
Assertions check the timing on every cycle:
- the verdict stays low while an address is being gathered;
- a start marker clears it on the next cycle;
- it rises one cycle after the final byte;
- it then holds steady until the next start;
- promiscuous mode always gives an accept.

Which addresses are accepted can only be shown by the bench's scenarios. Those cover the CRC-derived hash index for 64 group addresses, each tried with its own hash bit and with a neighbouring bit. They also cover station mismatches in each byte position, broadcast with and without the mode bit, ignored select codes, and streams with idle gaps.

// File: rtl/dfilt_pkg.sv
package dfilt_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W     = ADDR_BYTES * 8;
  localparam int CFG_W      = 32;
  localparam int CRC_W      = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;
  localparam int HASH_IDX_W = 6;
  localparam int HASH_BITS  = 1 << HASH_IDX_W;
  localparam int HASH_WORDS = HASH_BITS / CFG_W;
  localparam int SEL_W      = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_STA_LO = 3'd0,
    SEL_STA_HI = 3'd1,
    SEL_HASH0  = 3'd2,
    SEL_HASH1  = 3'd3,
    SEL_MODE   = 3'd4
  } cfg_sel_e;

  typedef struct packed {
    logic bcast_ok;
    logic promisc;
  } mode_t;

  // One byte into the CRC register, least significant bit first.
  function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] c_in,
                                                 input logic [7:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      fb = c[CRC_W-1] ^ d[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction
endpackage

// File: rtl/dfilt_regs.sv
module dfilt_regs
  import dfilt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [CFG_W-1:0]  wr_data,
  output logic [ADDR_W-1:0] station_o,
  output logic [HASH_BITS-1:0] hash_o,
  output mode_t             mode_o
);
  localparam int STA_HI_W = ADDR_W - CFG_W;

  logic [CFG_W-1:0]    sta_lo_q, sta_lo_d;
  logic [STA_HI_W-1:0] sta_hi_q, sta_hi_d;
  mode_t               mode_q, mode_d;
  logic                sta_lo_en, sta_hi_en, mode_en;
  logic [HASH_WORDS-1:0][CFG_W-1:0] hash_q;

  assign sta_lo_en = wr_en && (wr_sel == SEL_STA_LO);
  assign sta_hi_en = wr_en && (wr_sel == SEL_STA_HI);
  assign mode_en   = wr_en && (wr_sel == SEL_MODE);

  always_comb begin
    sta_lo_d = sta_lo_q;
    sta_hi_d = sta_hi_q;
    mode_d   = mode_q;
    if (sta_lo_en) sta_lo_d = wr_data;
    if (sta_hi_en) sta_hi_d = wr_data[STA_HI_W-1:0];
    if (mode_en)   mode_d   = mode_t'(wr_data[$bits(mode_t)-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sta_lo_q <= '0;
      sta_hi_q <= '0;
      mode_q   <= '0;
    end else begin
      sta_lo_q <= sta_lo_d;
      sta_hi_q <= sta_hi_d;
      mode_q   <= mode_d;
    end
  end

  for (genvar g = 0; g < HASH_WORDS; g++) begin : g_hash
    logic             en;
    logic [CFG_W-1:0] word_d;
    assign en = wr_en && (wr_sel == SEL_W'(int'(SEL_HASH0) + g));
    always_comb begin
      word_d = hash_q[g];
      if (en) word_d = wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hash_q[g] <= '0;
      else        hash_q[g] <= word_d;
    end
  end

  assign station_o = {sta_hi_q, sta_lo_q};
  assign hash_o    = hash_q;
  assign mode_o    = mode_q;
endmodule

// File: rtl/dfilt_collect.sv
module dfilt_collect
  import dfilt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic                  in_sof,
  input  logic [7:0]            in_data,
  output logic [ADDR_W-1:0]     addr_nxt_o,
  output logic [HASH_IDX_W-1:0] idx_nxt_o,
  output logic                  last_byte_o,
  output logic                  start_o,
  output logic                  busy_o
);
  localparam int CNT_W = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(ADDR_BYTES);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CRC_W-1:0]  crc_q, crc_d;
  logic              start, take, gather;

  assign gather = (cnt_q != '0) && (cnt_q < CNT_FULL);
  assign start  = in_valid && in_sof;
  assign take   = start || (in_valid && gather);

  always_comb begin
    cnt_d  = cnt_q;
    addr_d = addr_q;
    crc_d  = crc_q;
    if (start) begin
      cnt_d  = CNT_W'(1);
      addr_d = {{(ADDR_W-8){1'b0}}, in_data};
      crc_d  = crc_byte({CRC_W{1'b1}}, in_data);
    end else if (take) begin
      cnt_d  = cnt_q + CNT_W'(1);
      addr_d = {addr_q[ADDR_W-9:0], in_data};
      crc_d  = crc_byte(crc_q, in_data);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      addr_q <= '0;
      crc_q  <= '0;
    end else begin
      cnt_q  <= cnt_d;
      addr_q <= addr_d;
      crc_q  <= crc_d;
    end
  end

  assign addr_nxt_o  = addr_d;
  assign idx_nxt_o   = crc_d[CRC_W-1 -: HASH_IDX_W];
  assign last_byte_o = take && (cnt_d == CNT_FULL);
  assign start_o     = start;
  assign busy_o      = gather;

  assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);
endmodule

// File: rtl/dfilt_decide.sv
module dfilt_decide
  import dfilt_pkg::*;
(
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [HASH_IDX_W-1:0] idx_i,
  input  logic [ADDR_W-1:0]     station_i,
  input  logic [HASH_BITS-1:0]  hash_i,
  input  mode_t                 mode_i,
  output logic                  accept_o
);
  logic is_bcast, is_group, sta_hit, hash_hit;

  assign is_bcast = &addr_i;
  assign is_group = addr_i[ADDR_W-8];
  assign sta_hit  = (addr_i == station_i);
  assign hash_hit = hash_i[idx_i];

  always_comb begin
    if (mode_i.promisc)  accept_o = 1'b1;
    else if (is_bcast)   accept_o = mode_i.bcast_ok;
    else                 accept_o = sta_hit || (is_group && hash_hit);
  end
endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter
  import dfilt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic             rx_sof,
  input  logic [7:0]       rx_data,
  input  logic             cfg_wr_en,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             match_valid,
  output logic             match_accept
);
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [ADDR_W-1:0]     station;
  logic [HASH_BITS-1:0]  hash_tbl;
  mode_t                 mode;
  logic [ADDR_W-1:0]     addr_nxt;
  logic [HASH_IDX_W-1:0] idx_nxt;
  logic                  last_byte, start, busy, verdict;
  logic                  valid_q, valid_d, accept_q, accept_d;

  dfilt_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(cfg_wr_en), .wr_sel(cfg_sel),
    .wr_data(cfg_wdata), .station_o(station), .hash_o(hash_tbl), .mode_o(mode)
  );

  dfilt_collect u_collect (
    .clk(clk), .rst_n(rst_sync_n), .in_valid(rx_valid), .in_sof(rx_sof),
    .in_data(rx_data), .addr_nxt_o(addr_nxt), .idx_nxt_o(idx_nxt),
    .last_byte_o(last_byte), .start_o(start), .busy_o(busy)
  );

  dfilt_decide u_decide (
    .addr_i(addr_nxt), .idx_i(idx_nxt), .station_i(station),
    .hash_i(hash_tbl), .mode_i(mode), .accept_o(verdict)
  );

  always_comb begin
    valid_d  = valid_q;
    accept_d = accept_q;
    if (last_byte) begin
      valid_d  = 1'b1;
      accept_d = verdict;
    end else if (start) begin
      valid_d  = 1'b0;
      accept_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q  <= 1'b0;
      accept_q <= 1'b0;
    end else begin
      valid_q  <= valid_d;
      accept_q <= accept_d;
    end
  end

  assign match_valid  = valid_q;
  assign match_accept = accept_q;

  assert_low_midframe_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy |-> !match_valid);
  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rx_valid && rx_sof) |=> !match_valid);
  assert_valid_after_last_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    last_byte |=> match_valid);
  assert_accept_qualified_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    match_accept |-> match_valid);
  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (match_valid && !(rx_valid && rx_sof)) |=> (match_valid && $stable(match_accept)));
  assert_promisc_accepts_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (last_byte && mode.promisc) |=> match_accept);
endmodule

// File: tb/dst_addr_filter_tb_top.sv
module dst_addr_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, rx_sof = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        cfg_wr_en = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        match_valid, match_accept;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  logic [47:0] sh_sta  = '0;
  logic [63:0] sh_hash = '0;
  logic [1:0]  sh_mode = '0;

  always #2 clk = ~clk;

  dst_addr_filter dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_data(rx_data),
    .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .match_valid(match_valid), .match_accept(match_accept)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic check(input logic act, input logic exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [47:0] a);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < 6; i++) begin
      logic [7:0] b = a[47-8*i -: 8];
      for (int j = 0; j < 8; j++) begin
        logic fb = c[31] ^ b[j];
        c = c << 1;
        if (fb) c = c ^ 32'h04C11DB7;
      end
    end
    return c;
  endfunction

  function automatic logic ref_accept(input logic [47:0] a);
    logic [31:0] c = ref_crc(a);
    if (sh_mode[0]) return 1'b1;
    if (a == 48'hFFFF_FFFF_FFFF) return sh_mode[1];
    if (a == sh_sta) return 1'b1;
    if (a[40]) return sh_hash[c[31:26]];
    return 1'b0;
  endfunction

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    case (sel)
      3'd0: sh_sta[31:0]  = d;
      3'd1: sh_sta[47:32] = d[15:0];
      3'd2: sh_hash[31:0] = d;
      3'd3: sh_hash[63:32] = d;
      3'd4: sh_mode = d[1:0];
      default: ;
    endcase
  endtask

  task automatic set_hash(input logic [63:0] h);
    wr(3'd2, h[31:0]);
    wr(3'd3, h[63:32]);
  endtask

  task automatic send(input logic [47:0] a, input bit gaps, input string req);
    logic exp = ref_accept(a);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i > 0) check(match_valid, 1'b0, "R2 midframe");
      rx_valid = 1'b1; rx_sof = (i == 0); rx_data = a[47-8*i -: 8];
      if (gaps) begin
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0;
      end
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0;
    check(match_valid, 1'b1, "R2 valid after sixth byte");
    check(match_accept, exp, req);
  endtask

  initial begin
    logic [47:0] a;
    logic [31:0] c;
    logic [5:0]  idx;
    logic        held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(match_valid, 1'b0, "R1 reset valid");
    check(match_accept, 1'b0, "R1 reset accept");

    // R10: bytes with no start marker yield nothing
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = 1'b0; rx_data = 8'hA0 + 8'(i);
    end
    @(negedge clk); rx_valid = 1'b0;
    @(negedge clk);
    check(match_valid, 1'b0, "R10 no verdict without start");

    // R1: zeroed config rejects a plain unicast address
    send(48'h0A11_2233_4455, 1'b0, "R1 zero config rejects unicast");

    // R4: station match and per-byte mismatch
    wr(3'd1, 32'h0000_0211);
    wr(3'd0, 32'h2233_4455);
    send(48'h0211_2233_4455, 1'b0, "R4 station match");
    for (int p = 0; p < 6; p++) begin
      a = 48'h0211_2233_4455 ^ (48'h02 << (8*(5-p)));
      send(a, 1'b0, "R4 station mismatch");
    end
    send(48'h0211_2233_4455, 1'b1, "R4 station match with gaps R2");

    // R5/R6: sweep of group addresses, own index and neighbour index
    for (int k = 0; k < 64; k++) begin
      a = {8'h01, 8'h00, 8'h5E, 8'h00, 8'(k * 7), 8'(k)};
      c = ref_crc(a);
      idx = c[31:26];
      set_hash(64'd1 << idx);
      send(a, 1'b0, "R5 R6 hash bit set accepts");
      set_hash(64'd1 << (idx ^ 6'd1));
      send(a, 1'b0, "R5 R6 other hash bit rejects");
    end

    // R5: all-ones table, group accepted, foreign unicast still rejected
    set_hash('1);
    send(48'h3300_0000_0001, 1'b0, "R5 all ones table accepts group");
    send(48'h0A00_0000_0001, 1'b0, "R5 unicast not matched by table");

    // R7: broadcast gated by mode bit 1, ahead of hash
    send(48'hFFFF_FFFF_FFFF, 1'b0, "R7 broadcast rejected without mode bit");
    wr(3'd4, 32'h2);
    send(48'hFFFF_FFFF_FFFF, 1'b0, "R7 broadcast accepted with mode bit");

    // R9: unused selects ignored
    wr(3'd4, 32'h0);
    set_hash('0);
    for (int s = 5; s < 8; s++) begin
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_sel = 3'(s); cfg_wdata = '1;
      @(negedge clk);
      cfg_wr_en = 1'b0;
    end
    send(48'hFFFF_FFFF_FFFF, 1'b0, "R9 mode unchanged by unused select");
    send(48'h0100_5E00_0001, 1'b0, "R9 hash unchanged by unused select");
    send(48'h0211_2233_4455, 1'b0, "R9 station unchanged by unused select");

    // R8: promiscuous
    wr(3'd4, 32'h1);
    send(48'h0A0B_0C0D_0E0F, 1'b0, "R8 promiscuous unicast");
    send(48'h0100_5E00_0009, 1'b0, "R8 promiscuous group");
    send(48'hFFFF_FFFF_FFFF, 1'b1, "R8 promiscuous broadcast");

    // R3: verdict held across config writes and trailing bytes
    wr(3'd4, 32'h0);
    send(48'h0A0B_0C0D_0E0F, 1'b0, "R3 setup reject");
    held = match_accept;
    wr(3'd4, 32'h1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = 1'b0; rx_data = 8'h55;
    end
    @(negedge clk); rx_valid = 1'b0;
    check(match_valid, 1'b1, "R3 valid held");
    check(match_accept, held, "R3 accept held");
    @(negedge clk);
    rx_valid = 1'b1; rx_sof = 1'b1; rx_data = 8'h0A;
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0;
    check(match_valid, 1'b0, "R2 start clears verdict");

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule